// File: doc/BRIEF.md
# Bit-Error Counter with Latched Status and Interrupt

This block sits behind the receive side of a bit-error-rate tester. Each clock cycle the receiver may raise a single-cycle strobe that marks one received data bit as wrong. The block counts those strobes in a saturating counter and reports three conditions through sticky latches: the receiver's sync flag changed, an error bit was seen, and the counter hit its ceiling. The latches can be enabled one by one. The enabled ones are combined into a summary bit, and that bit, through one more enable, drives an active-low interrupt.

Counting starts the first time the receiver reports sync. It does not stop if sync is lost later, so an error burst that breaks sync is still counted. The host zeroes the count by taking a control bit from low to high. It clears all three latches by reading the status register, which is signalled to the block by a one-cycle read strobe. The count is wider than a host read, so the lower part is shown live. Reading the lower part captures the upper part into a holding register, which lets the host take the two halves as one consistent value.

Top module: `bert_err_cnt`

## Requirements
- R1: After synchronous active-high reset, the low count output, the held upper count, all three latches and the summary are 0, and the interrupt output is 1 (inactive).
- R2: While counting is enabled, each cycle with the error strobe high adds exactly 1 to the count. The count becomes visible on the cycle after the strobe is sampled.
- R3: Counting is enabled in any cycle where the sync input is 1, and in every cycle after the sync input was first sampled 1. Before that, error strobes leave the count at 0.
- R4: The count saturates at 2^CNT_W-1. Further error strobes leave it there and never wrap it to 0.
- R5: The overflow latch sets one cycle after the count first reaches 2^CNT_W-1. It sets again each time the count comes back to the ceiling after a clear.
- R6: A 0-to-1 change of the clear control bit, seen at one clock edge, makes the count read 0 after the next edge. That clear takes priority over an error strobe sampled at that next edge. Holding the bit high does not clear again.
- R7: The sync-change latch sets on the cycle after the sync input differs from its value at the previous edge. Its value before the first edge after reset is taken as 0.
- R8: The error latch sets on the cycle after an error strobe is sampled while counting is enabled.
- R9: A status-read strobe clears all three latches. A latch whose event is sampled at the same edge as the read stays set. Without a read, a set latch stays set.
- R10: The summary output is the OR of each latch ANDed with its own enable. The interrupt output is 0 exactly when the summary is 1 and the interrupt enable is 1.
- R11: The low output shows the live lower LOW_W bits of the count. The upper output shows the upper CNT_W-LOW_W bits captured at the last edge where the low-read strobe was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| errStrobe | input | 1 | One received bit was in error this cycle |
| rxSync | input | 1 | Receiver is in sync (1) |
| loadClr | input | 1 | Clear control bit; a 0-to-1 change clears the count |
| statRead | input | 1 | Host read the status register this cycle |
| rdLow | input | 1 | Host read the lower count this cycle; captures the upper part |
| ieSync | input | 1 | Enable for the sync-change latch |
| ieErr | input | 1 | Enable for the error latch |
| ieOvf | input | 1 | Enable for the overflow latch |
| ieSummary | input | 1 | Enable from summary to interrupt |
| cntLow | output | LOW_W (8) | Live lower count bits |
| cntHigh | output | CNT_W-LOW_W (16) | Captured upper count bits |
| latSync | output | 1 | Sync-change latch |
| latErr | output | 1 | Error-seen latch |
| latOvf | output | 1 | Counter-overflow latch |
| summary | output | 1 | OR of enabled latches |
| intN | output | 1 | Interrupt, active low |

## Verification
The counter is built with a narrow width, so saturation comes within about a thousand strobes. Several strobe patterns are applied. Strobes before any sync show whether arming works. Strobes after sync is dropped show that counting continues. A long unbroken run shows that saturation holds instead of wrapping and that the overflow latch sets once. A clear edge with a strobe in the cycle that follows shows which of the two wins. Status reads that coincide with events show whether an event survives the clear. A long random stretch mixes all inputs, including frequent captures of the upper half, and compares every output on every cycle against a cycle model.

// File: rtl/bert_err_pkg.sv
package bert_err_pkg;
  typedef struct packed {
    logic inc;
    logic clr;
  } dpStrobes_t;

  localparam int LAT_N    = 3;
  localparam int IDX_SYNC = 0;
  localparam int IDX_ERR  = 1;
  localparam int IDX_OVF  = 2;
endpackage

// File: rtl/bert_err_dp.sv
module bert_err_dp
  import bert_err_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int LOW_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  dpStrobes_t         strobes,
  input  logic               rdLow,
  output logic [LOW_W-1:0]   cntLow,
  output logic [CNT_W-LOW_W-1:0] cntHigh,
  output logic               cntFull
);
  localparam int HIGH_W = CNT_W - LOW_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  cnt;
  logic [HIGH_W-1:0] highSnap;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (strobes.clr) begin
      cnt <= '0;
    end else if (strobes.inc && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      highSnap <= '0;
    end else if (rdLow) begin
      highSnap <= cnt[CNT_W-1:LOW_W];
    end
  end

  assign cntLow  = cnt[LOW_W-1:0];
  assign cntHigh = highSnap;
  assign cntFull = (cnt == CNT_MAX);

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    !strobes.clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1)); // R2
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cntFull && !strobes.clr) |=> cntFull); // R4
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    strobes.clr |=> (cnt == '0)); // R6
  AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (rst)
    rdLow |=> (cntHigh == $past(cnt[CNT_W-1:LOW_W]))); // R11
endmodule

// File: rtl/bert_err_ctrl.sv
module bert_err_ctrl
  import bert_err_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       errStrobe,
  input  logic       rxSync,
  input  logic       loadClr,
  input  logic       statRead,
  input  logic       ieSync,
  input  logic       ieErr,
  input  logic       ieOvf,
  input  logic       ieSummary,
  input  logic       cntFull,
  output dpStrobes_t strobes,
  output logic       latSync,
  output logic       latErr,
  output logic       latOvf,
  output logic       summary,
  output logic       intN
);
  logic lcQ, clrReq, armed, syncQ, fullQ;
  logic countEn;
  logic [LAT_N-1:0] evt, latQ, ieVec;

  always_ff @(posedge clk) begin
    if (rst) begin
      lcQ    <= 1'b0;
      clrReq <= 1'b0;
      armed  <= 1'b0;
      syncQ  <= 1'b0;
      fullQ  <= 1'b0;
    end else begin
      lcQ    <= loadClr;
      clrReq <= loadClr & ~lcQ;
      armed  <= armed | rxSync;
      syncQ  <= rxSync;
      fullQ  <= cntFull;
    end
  end

  assign countEn     = armed | rxSync;
  assign strobes.clr = clrReq;
  assign strobes.inc = errStrobe & countEn & ~clrReq;

  always_comb begin
    evt           = '0;
    evt[IDX_SYNC] = rxSync ^ syncQ;
    evt[IDX_ERR]  = errStrobe & countEn;
    evt[IDX_OVF]  = cntFull & ~fullQ;
    ieVec           = '0;
    ieVec[IDX_SYNC] = ieSync;
    ieVec[IDX_ERR]  = ieErr;
    ieVec[IDX_OVF]  = ieOvf;
  end

  for (genvar g = 0; g < LAT_N; g++) begin : gLat
    always_ff @(posedge clk) begin
      if (rst) begin
        latQ[g] <= 1'b0;
      end else begin
        latQ[g] <= (latQ[g] & ~statRead) | evt[g];
      end
    end
  end

  assign latSync = latQ[IDX_SYNC];
  assign latErr  = latQ[IDX_ERR];
  assign latOvf  = latQ[IDX_OVF];
  assign summary = |(latQ & ieVec);
  assign intN    = ~(summary & ieSummary);

  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed); // R3
  AST_CLR_ONESHOT: assert property (@(posedge clk) disable iff (rst)
    clrReq |=> !clrReq); // R6
  AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (rst)
    (latErr && !statRead) |=> latErr); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (statRead && !evt[IDX_SYNC]) |=> !latSync); // R9
  AST_INT_SOURCE: assert property (@(posedge clk) disable iff (rst)
    !intN |-> (ieSummary && (latSync || latErr || latOvf))); // R10
endmodule

// File: rtl/bert_err_cnt.sv
module bert_err_cnt
  import bert_err_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int LOW_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   errStrobe,
  input  logic                   rxSync,
  input  logic                   loadClr,
  input  logic                   statRead,
  input  logic                   rdLow,
  input  logic                   ieSync,
  input  logic                   ieErr,
  input  logic                   ieOvf,
  input  logic                   ieSummary,
  output logic [LOW_W-1:0]       cntLow,
  output logic [CNT_W-LOW_W-1:0] cntHigh,
  output logic                   latSync,
  output logic                   latErr,
  output logic                   latOvf,
  output logic                   summary,
  output logic                   intN
);
  dpStrobes_t strobes;
  logic cntFull;

  bert_err_ctrl ctrl_i (
    .clk(clk), .rst(rst), .errStrobe(errStrobe), .rxSync(rxSync),
    .loadClr(loadClr), .statRead(statRead), .ieSync(ieSync), .ieErr(ieErr),
    .ieOvf(ieOvf), .ieSummary(ieSummary), .cntFull(cntFull), .strobes(strobes),
    .latSync(latSync), .latErr(latErr), .latOvf(latOvf), .summary(summary),
    .intN(intN)
  );

  bert_err_dp #(.CNT_W(CNT_W), .LOW_W(LOW_W)) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes), .rdLow(rdLow),
    .cntLow(cntLow), .cntHigh(cntHigh), .cntFull(cntFull)
  );
endmodule

// File: tb/bert_err_cnt_tb_top.sv
module bert_err_cnt_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;
  localparam int LW = 4;
  localparam int HW = CW - LW;
  localparam int MAXV = (1 << CW) - 1;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic errStrobe = 0, rxSync = 0, loadClr = 0, statRead = 0, rdLow = 0;
  logic ieSync = 0, ieErr = 0, ieOvf = 0, ieSummary = 0;
  logic [LW-1:0] cntLow;
  logic [HW-1:0] cntHigh;
  logic latSync, latErr, latOvf, summary, intN;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  // cycle model built from the requirements
  int mCnt = 0, mSnap = 0;
  bit mArmed = 0, mLcQ = 0, mClrReq = 0, mSyncQ = 0, mFullQ = 0;
  bit mLatS = 0, mLatE = 0, mLatO = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bert_err_cnt #(.CNT_W(CW), .LOW_W(LW)) dut_i (
    .clk(clk), .rst(rst), .errStrobe(errStrobe), .rxSync(rxSync),
    .loadClr(loadClr), .statRead(statRead), .rdLow(rdLow), .ieSync(ieSync),
    .ieErr(ieErr), .ieOvf(ieOvf), .ieSummary(ieSummary), .cntLow(cntLow),
    .cntHigh(cntHigh), .latSync(latSync), .latErr(latErr), .latOvf(latOvf),
    .summary(summary), .intN(intN)
  );

  function automatic bit expSummary();
    return (mLatS & ieSync) | (mLatE & ieErr) | (mLatO & ieOvf);
  endfunction

  function automatic bit expIntN();
    return !(expSummary() && ieSummary);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic compareAll();
    chk("R2 low count", int'(cntLow), mCnt & ((1 << LW) - 1));
    chk("R11 held upper", int'(cntHigh), mSnap);
    chk("R7 sync latch", int'(latSync), int'(mLatS));
    chk("R8 error latch", int'(latErr), int'(mLatE));
    chk("R5 overflow latch", int'(latOvf), int'(mLatO));
    chk("R10 summary", int'(summary), int'(expSummary()));
    chk("R10 interrupt", int'(intN), int'(expIntN()));
  endtask

  task automatic step();
    bit en, inc, full;
    int nCnt;
    if (rst) begin
      nCnt = 0; mSnap = 0; mArmed = 0; mLcQ = 0; mClrReq = 0;
      mSyncQ = 0; mFullQ = 0; mLatS = 0; mLatE = 0; mLatO = 0;
    end else begin
      en   = mArmed | rxSync;
      inc  = errStrobe & en & !mClrReq;
      full = (mCnt == MAXV);
      nCnt = mClrReq ? 0 : ((inc && mCnt != MAXV) ? mCnt + 1 : mCnt);
      if (rdLow) mSnap = mCnt >> LW;
      mLatS = (mLatS & !statRead) | (rxSync ^ mSyncQ);
      mLatE = (mLatE & !statRead) | (errStrobe & en);
      mLatO = (mLatO & !statRead) | (full & !mFullQ);
      mFullQ  = full;
      mClrReq = loadClr & !mLcQ;
      mLcQ    = loadClr;
      mArmed  = mArmed | rxSync;
      mSyncQ  = rxSync;
    end
    mCnt = nCnt;
    @(posedge clk);
    #1;
    cycles++;
    if (!rst) compareAll();
  endtask

  task automatic readCount(output int v);
    errStrobe = 0; rdLow = 1;
    step();
    rdLow = 0;
    v = (int'(cntHigh) << LW) | int'(cntLow);
  endtask

  initial begin
    int v;
    int sd;
    sd = $urandom(32'd24681);
    rst = 1;
    repeat (3) step();
    rst = 0;
    step();
    // R1 reset state
    chk("R1 low", int'(cntLow), 0);
    chk("R1 upper", int'(cntHigh), 0);
    chk("R1 latches", int'({latSync, latErr, latOvf}), 0);
    chk("R1 intN", int'(intN), 1);

    // R3: strobes before any sync are not counted
    errStrobe = 1;
    repeat (5) step();
    readCount(v);
    chk("R3 no count before sync", v, 0);
    chk("R3 no error latch before sync", int'(latErr), 0);

    // sync rises: R7, counting R2
    ieSync = 1; ieErr = 1; ieSummary = 1;
    rxSync = 1; step();
    chk("R7 sync change seen", int'(latSync), 1);
    chk("R10 interrupt active", int'(intN), 0);
    errStrobe = 1; repeat (7) step();
    readCount(v);
    chk("R2 seven errors", v, 7);
    chk("R8 error latch", int'(latErr), 1);

    // R3: sync lost, still counting
    rxSync = 0; errStrobe = 1; repeat (4) step();
    readCount(v);
    chk("R3 counting after sync loss", v, 11);

    // R9: read clears; read with coincident event keeps it
    statRead = 1; step(); statRead = 0;
    chk("R9 read clears sync latch", int'(latSync), 0);
    chk("R9 read clears error latch", int'(latErr), 0);
    statRead = 1; errStrobe = 1; step(); statRead = 0; errStrobe = 0;
    chk("R9 coincident event kept", int'(latErr), 1);
    step();
    chk("R9 latch held without read", int'(latErr), 1);

    // R10 masks
    ieErr = 0; ieSync = 0; step();
    chk("R10 masked summary", int'(summary), 0);
    chk("R10 masked intN", int'(intN), 1);
    ieErr = 1; ieSummary = 0; step();
    chk("R10 summary on, int disabled", int'(intN), 1);
    ieSummary = 1;

    // R6: clear edge, strobe in clear cycle loses, held high no reclear
    loadClr = 1; errStrobe = 1; step();
    step();
    errStrobe = 0;
    readCount(v);
    chk("R6 clear wins over strobe", v, 0);
    errStrobe = 1; repeat (3) step(); errStrobe = 0;
    readCount(v);
    chk("R6 held high no reclear", v, 3);
    loadClr = 0; step();

    // R4/R5 saturation
    ieOvf = 1; statRead = 1; step(); statRead = 0;
    errStrobe = 1;
    repeat (MAXV + 20) step();
    errStrobe = 0;
    readCount(v);
    chk("R4 saturated", v, MAXV);
    chk("R5 overflow latch", int'(latOvf), 1);

    // R11 two-step read coherence after clear
    loadClr = 1; step(); step(); loadClr = 0; step();
    errStrobe = 1; repeat (37) step(); errStrobe = 0;
    readCount(v);
    chk("R11 coherent read", v, 37);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      errStrobe = ($urandom % 4) != 0;
      rxSync    = ($urandom % 8) == 0 ? !rxSync : rxSync;
      loadClr   = ($urandom % 64) == 0 ? !loadClr : loadClr;
      statRead  = ($urandom % 10) == 0;
      rdLow     = ($urandom % 3) == 0;
      ieSync    = $urandom % 2; ieErr = $urandom % 2;
      ieOvf     = $urandom % 2; ieSummary = ($urandom % 4) != 0;
      step();
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule